// File: doc/BRIEF.md
# Load Result Extractor and Unpacker

This block sits after the data-return stage of a load pipeline. It turns the raw little-endian bytes that came back from memory into the exact value written to a destination register. A single 4-bit operation code selects what happens: scalar extension of a byte, halfword, word or doubleword; unpacking of two or four bytes into 16-bit lanes with zero or sign fill; or a shift-in merge in which new data enters the top of the previous 64-bit destination value while the older contents move down.

The raw word always arrives 64 bits wide. Byte 0 (bits 7:0) is the byte at the lowest address, and bytes beyond the access size are don't-care. The old destination value is needed only by the two merge operations. The result is registered once, so it appears one clock after the request together with a flag that marks a 64-bit register-pair write.

Top module: `ldx_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_pair` and `out_data` are all zero.
- R2: `out_valid` equals `in_valid` from the previous cycle. A cycle with `in_valid` low leaves `out_data` and `out_pair` unchanged.
- R3: Op 0 zero-extends `in_raw[7:0]` to 32 bits. Op 1 sign-extends it to 32 bits.
- R4: Op 2 zero-extends `in_raw[15:0]` to 32 bits. Op 3 sign-extends it to 32 bits.
- R5: Op 4 passes `in_raw[31:0]` through. Every 32-bit result (ops 0-4, 6, 7) has `out_data[63:32]` equal to zero and `out_pair` low.
- R6: Op 5 passes all 64 bits of `in_raw` through. `out_pair` is high for ops 5, 8, 9, 10 and 11.
- R7: Op 6 (two-lane zero unpack) puts byte i of `in_raw` into bits 16i+7:16i for i = 0, 1. Bits 16i+15:16i+8 are cleared, and the result is 32 bits wide.
- R8: Op 8 (four-lane zero unpack) puts byte i into the low half of 16-bit lane i for i = 0..3. The upper half of each lane is cleared, and the result is 64 bits wide.
- R9: Op 7 and op 9 behave like ops 6 and 8, except that each byte is sign-extended across its 16-bit lane.
- R10: Op 10 (halfword merge) returns `in_old` shifted right by 16, with `in_raw[15:0]` placed at bits 63:48.
- R11: Op 11 (byte merge) returns `in_old` shifted right by 8, with `in_raw[7:0]` placed at bits 63:56.
- R12: Raw bytes above the access size of the selected operation do not affect the result.
- R13: Op codes 12 to 15 are unused. They produce an all-zero result with `out_pair` low.
- R14: `in_old` affects the result only for ops 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_raw | input | 64 | Raw load bytes, byte 0 at bits 7:0 |
| in_old | input | 64 | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Destination value |
| out_pair | output | 1 | High when the full 64-bit register pair is written |

## Verification
The assertions check the following properties on every cycle:
- valid tracking and hold (R2);
- the zero upper half that comes with a low pair flag (R5);
- the pair flag for each op code (R6);
- the pass-through of the double load (R6);
- the shifted-down portion of both merge operations (R10, R11);
- the zero result for unused codes (R13).

The bench sweeps every op code against all 256 values of the low raw byte, while the upper raw bytes and the old value carry pseudo-random contents. Only this sweep can show the exact sign-fill and lane placement of the extensions and unpacks (R3, R4, R7-R9). It is also what shows that upper raw bytes and the old value leave non-merge results untouched (R12, R14).

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PAIR_W  = 64;
    localparam int unsigned OP_W    = 4;
    localparam int unsigned NBYTES  = PAIR_W / BYTE_W;

    typedef enum logic [OP_W-1:0] {
        OP_U8      = 4'd0,
        OP_S8      = 4'd1,
        OP_U16     = 4'd2,
        OP_S16     = 4'd3,
        OP_W32     = 4'd4,
        OP_D64     = 4'd5,
        OP_UNPK2Z  = 4'd6,
        OP_UNPK2S  = 4'd7,
        OP_UNPK4Z  = 4'd8,
        OP_UNPK4S  = 4'd9,
        OP_MERGE_H = 4'd10,
        OP_MERGE_B = 4'd11
    } ldx_op_e;

    typedef enum logic [1:0] {
        GRP_SCALAR = 2'd0,
        GRP_UNPACK = 2'd1,
        GRP_MERGE  = 2'd2,
        GRP_NONE   = 2'd3
    } ldx_grp_e;

    // size: log2 of the access width in bytes
    typedef struct packed {
        ldx_grp_e    grp;
        logic [1:0]  size;
        logic        sext;
        logic        wide;
        logic        pair;
    } ldx_ctrl_t;

    typedef struct packed {
        logic [PAIR_W-1:0] data;
        logic              pair;
    } ldx_res_t;

    function automatic ldx_ctrl_t ldx_decode(input logic [OP_W-1:0] op);
        ldx_ctrl_t c;
        c = '{grp: GRP_NONE, size: 2'd0, sext: 1'b0, wide: 1'b0, pair: 1'b0};
        case (op)
            OP_U8:      begin c.grp = GRP_SCALAR; c.size = 2'd0; end
            OP_S8:      begin c.grp = GRP_SCALAR; c.size = 2'd0; c.sext = 1'b1; end
            OP_U16:     begin c.grp = GRP_SCALAR; c.size = 2'd1; end
            OP_S16:     begin c.grp = GRP_SCALAR; c.size = 2'd1; c.sext = 1'b1; end
            OP_W32:     begin c.grp = GRP_SCALAR; c.size = 2'd2; end
            OP_D64:     begin c.grp = GRP_SCALAR; c.size = 2'd3; c.pair = 1'b1; end
            OP_UNPK2Z:  begin c.grp = GRP_UNPACK; c.size = 2'd1; end
            OP_UNPK2S:  begin c.grp = GRP_UNPACK; c.size = 2'd1; c.sext = 1'b1; end
            OP_UNPK4Z:  begin c.grp = GRP_UNPACK; c.size = 2'd2; c.wide = 1'b1; c.pair = 1'b1; end
            OP_UNPK4S:  begin c.grp = GRP_UNPACK; c.size = 2'd2; c.wide = 1'b1; c.sext = 1'b1; c.pair = 1'b1; end
            OP_MERGE_H: begin c.grp = GRP_MERGE;  c.size = 2'd1; c.pair = 1'b1; end
            OP_MERGE_B: begin c.grp = GRP_MERGE;  c.size = 2'd0; c.pair = 1'b1; end
            default:    c.grp = GRP_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ldx_extend.sv
// Scalar extension of byte / half / word, pass-through of double.
module ldx_extend
    import ldx_pkg::*;
#(
    parameter int unsigned DW = PAIR_W,
    parameter int unsigned RW = WORD_W
) (
    input  logic [DW-1:0] raw,
    input  logic [1:0]    size,
    input  logic          sext,
    output logic [DW-1:0] y
);
    localparam int unsigned UPPER_W = DW - RW;

    logic [RW-1:0] narrow;
    logic          fill_b;
    logic          fill_h;

    assign fill_b = sext & raw[BYTE_W-1];
    assign fill_h = sext & raw[HALF_W-1];

    always_comb begin
        narrow = '0;
        case (size)
            2'd0:    narrow = {{(RW-BYTE_W){fill_b}}, raw[BYTE_W-1:0]};
            2'd1:    narrow = {{(RW-HALF_W){fill_h}}, raw[HALF_W-1:0]};
            default: narrow = raw[RW-1:0];
        endcase
        if (size == 2'd3) begin
            y = raw;
        end else begin
            y = {{UPPER_W{1'b0}}, narrow};
        end
    end
endmodule

// File: rtl/ldx_unpack.sv
// Byte-to-lane unpack: each enabled byte widens into one lane.
module ldx_unpack
    import ldx_pkg::*;
#(
    parameter int unsigned IN_LANE_W  = BYTE_W,
    parameter int unsigned OUT_LANE_W = HALF_W,
    parameter int unsigned MAX_LANES  = 4,
    parameter int unsigned DW         = PAIR_W
) (
    input  logic [DW-1:0] raw,
    input  logic          wide,
    input  logic          sext,
    output logic [DW-1:0] y
);
    localparam int unsigned NARROW_LANES = MAX_LANES / 2;
    localparam int unsigned FILL_W       = OUT_LANE_W - IN_LANE_W;
    localparam int unsigned USED_W       = MAX_LANES * OUT_LANE_W;

    logic [USED_W-1:0] lanes;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        logic [IN_LANE_W-1:0] b;
        logic                 en;
        assign b  = raw[i*IN_LANE_W +: IN_LANE_W];
        assign en = wide | (i < NARROW_LANES);
        assign lanes[i*OUT_LANE_W +: OUT_LANE_W] =
            en ? {{FILL_W{sext & b[IN_LANE_W-1]}}, b} : '0;
    end

    if (USED_W < DW) begin : g_pad
        assign y = {{(DW-USED_W){1'b0}}, lanes};
    end else begin : g_nopad
        assign y = lanes[DW-1:0];
    end
endmodule

// File: rtl/ldx_merge.sv
// Shift-in merge: new bytes enter at the top of the old value.
module ldx_merge
    import ldx_pkg::*;
#(
    parameter int unsigned DW = PAIR_W
) (
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] raw,
    input  logic          byte_mode,
    output logic [DW-1:0] y
);
    logic [DW-1:0] by_byte;
    logic [DW-1:0] by_half;

    assign by_byte = {raw[BYTE_W-1:0], old_val[DW-1:BYTE_W]};
    assign by_half = {raw[HALF_W-1:0], old_val[DW-1:HALF_W]};
    assign y       = byte_mode ? by_byte : by_half;
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [PAIR_W-1:0] in_raw,
    input  logic [PAIR_W-1:0] in_old,
    output logic              out_valid,
    output logic [PAIR_W-1:0] out_data,
    output logic              out_pair
);
    ldx_ctrl_t         ctrl;
    logic [PAIR_W-1:0] ext_y;
    logic [PAIR_W-1:0] unp_y;
    logic [PAIR_W-1:0] mrg_y;
    ldx_res_t          res_d;
    ldx_res_t          res_q;
    logic              vld_q;

    assign ctrl = ldx_decode(in_op);

    ldx_extend #(.DW(PAIR_W), .RW(WORD_W)) u_ext (
        .raw  (in_raw),
        .size (ctrl.size),
        .sext (ctrl.sext),
        .y    (ext_y)
    );

    ldx_unpack #(
        .IN_LANE_W (BYTE_W),
        .OUT_LANE_W(HALF_W),
        .MAX_LANES (PAIR_W / HALF_W),
        .DW        (PAIR_W)
    ) u_unp (
        .raw  (in_raw),
        .wide (ctrl.wide),
        .sext (ctrl.sext),
        .y    (unp_y)
    );

    ldx_merge #(.DW(PAIR_W)) u_mrg (
        .old_val  (in_old),
        .raw      (in_raw),
        .byte_mode(ctrl.size == 2'd0),
        .y        (mrg_y)
    );

    always_comb begin
        res_d.pair = ctrl.pair;
        case (ctrl.grp)
            GRP_SCALAR: res_d.data = ext_y;
            GRP_UNPACK: res_d.data = unp_y;
            GRP_MERGE:  res_d.data = mrg_y;
            default:    res_d.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_data  = res_q.data;
    assign out_pair  = res_q.pair;
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk
    import ldx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [PAIR_W-1:0] in_raw,
    input logic [PAIR_W-1:0] in_old,
    input logic              out_valid,
    input logic [PAIR_W-1:0] out_data,
    input logic              out_pair
);
    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_pair))); // R2
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pair) |-> (out_data[PAIR_W-1:WORD_W] == '0)); // R5
    AST_PAIR_SET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OP_D64 || in_op == OP_UNPK4Z || in_op == OP_UNPK4S ||
                      in_op == OP_MERGE_H || in_op == OP_MERGE_B)) |=> out_pair); // R6
    AST_PAIR_CLR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op <= OP_W32 || in_op == OP_UNPK2Z || in_op == OP_UNPK2S))
        |=> !out_pair); // R5
    AST_DOUBLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_D64) |=> (out_data == $past(in_raw))); // R6
    AST_MERGE_H_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MERGE_H) |=>
        (out_data[PAIR_W-HALF_W-1:0] == $past(in_old[PAIR_W-1:HALF_W]))); // R10
    AST_MERGE_B_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MERGE_B) |=>
        (out_data[PAIR_W-BYTE_W-1:0] == $past(in_old[PAIR_W-1:BYTE_W]))); // R11
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_MERGE_B) |=> (out_data == '0 && !out_pair)); // R13
endmodule

bind ldx_unit ldx_unit_chk u_chk (.*);

// File: tb/sim_ldx_unit.sv
`timescale 1ns/1ps
module sim_ldx_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic [63:0] in_raw = '0;
    logic [63:0] in_old = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_pair;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    ldx_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_raw(in_raw), .in_old(in_old),
        .out_valid(out_valid), .out_data(out_data), .out_pair(out_pair)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R5";
            5:       return "R6";
            6:       return "R7";
            8:       return "R8";
            7, 9:    return "R9";
            10:      return "R10";
            11:      return "R11";
            default: return "R13";
        endcase
    endfunction

    // Reference model written from the requirement text.
    // R12 / R14: only the named raw bytes and, for merges, the old value are used.
    function automatic logic [64:0] model(input int op, input logic [63:0] raw,
                                          input logic [63:0] old);
        logic [63:0] d;
        logic        p;
        int          v;
        int          nl;
        logic [63:0] lane;
        d = '0;
        p = 1'b0;
        case (op)
            0, 1: begin
                v = int'(raw[7:0]);
                if (op == 1 && v >= 128) v = v - 256;
                d = {32'h0, 32'(v)};
            end
            2, 3: begin
                v = int'(raw[15:0]);
                if (op == 3 && v >= 32768) v = v - 65536;
                d = {32'h0, 32'(v)};
            end
            4: d = {32'h0, raw[31:0]};
            5: begin d = raw; p = 1'b1; end
            6, 7, 8, 9: begin
                nl = (op >= 8) ? 4 : 2;
                for (int i = 0; i < nl; i++) begin
                    lane = 64'(raw[8*i +: 8]);
                    if ((op == 7 || op == 9) && lane >= 64'd128) lane = lane + 64'hFF00;
                    d = d + (lane << (16 * i));
                end
                p = (op >= 8);
            end
            10: begin d = (old >> 16) | ({48'h0, raw[15:0]} << 48); p = 1'b1; end
            11: begin d = (old >> 8) | ({56'h0, raw[7:0]} << 56); p = 1'b1; end
            default: begin d = '0; p = 1'b0; end
        endcase
        return {p, d};
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual pair=%0b data=%h expected pair=%0b data=%h",
                     req, act[64], act[63:0], exp[64], exp[63:0]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [64:0] exp_q;
        logic [64:0] hold_v;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {out_pair, out_data}, 65'h0);
        check("R1", {64'h0, out_valid}, 65'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {out_pair, out_data}, 65'h0);
        check("R1", {64'h0, out_valid}, 65'h0);

        // Sweep every op code against every low raw byte, back to back.
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 256; k++) begin
                seed = next_rand(seed);
                in_raw = {seed[63:8], 8'(k)};
                seed = next_rand(seed);
                in_old = seed;
                in_op = 4'(op);
                in_valid = 1'b1;
                exp_q = model(op, in_raw, in_old);
                @(negedge clk);
                check(req_of(op), {out_pair, out_data}, exp_q);
                check("R2", {64'h0, out_valid}, 65'h1);
            end
        end

        // Corners: sign boundary of halfwords and lanes (R4, R9)
        for (int c = 0; c < 4; c++) begin
            logic [63:0] pat;
            pat = (c == 0) ? 64'hFFFF_FFFF_8000_8000 :
                  (c == 1) ? 64'h0000_0000_7FFF_7FFF :
                  (c == 2) ? 64'h1234_5678_807F_FF01 : 64'hFFFF_FFFF_FFFF_FFFF;
            for (int op = 2; op < 10; op++) begin
                in_raw = pat;
                in_old = ~pat;
                in_op = 4'(op);
                in_valid = 1'b1;
                exp_q = model(op, in_raw, in_old);
                @(negedge clk);
                check(req_of(op), {out_pair, out_data}, exp_q);
            end
        end

        // R2: idle cycles hold the last result while inputs change
        hold_v = {out_pair, out_data};
        in_valid = 1'b0;
        for (int j = 0; j < 8; j++) begin
            seed = next_rand(seed);
            in_raw = seed;
            in_old = ~seed;
            in_op = 4'(j + 5);
            @(negedge clk);
            check("R2", {out_pair, out_data}, hold_v);
            check("R2", {64'h0, out_valid}, 65'h0);
        end

        // R11 then R10 chained: merge result fed back as old value
        in_valid = 1'b1;
        in_old = 64'h0102_0304_0506_0708;
        in_raw = 64'hAAAA_AAAA_AAAA_AA9C;
        in_op = 4'd11;
        @(negedge clk);
        check("R11", {out_pair, out_data}, {1'b1, 64'h9C01_0203_0405_0607});
        in_old = out_data;
        in_raw = 64'h5555_5555_5555_BEEF;
        in_op = 4'd10;
        @(negedge clk);
        check("R10", {out_pair, out_data}, {1'b1, 64'hBEEF_9C01_0203_0405});
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule